// File: doc/BRIEF.md
# Windowed Watchdog Timer with Postscaler

This block is a watchdog driven by a slow tick from an internal oscillator. An 8-bit base counter advances once per tick. Each time it wraps it advances a 16-bit postscaler. A 4-bit select field picks the postscaler tap that ends the timeout period. The timeout therefore spans 256 times 2^k ticks, where k is the select value. With a 4 ms base pass this gives periods from 4 ms up to about 131 s.

Software must strobe a clear before the timeout. When the timeout expires, the block pulses a reset request while the system is awake, or a wake-up request while it sleeps. In window mode a clear is accepted only in the last quarter of the base count. An early clear is itself treated as a fault and raises the reset request.

Several events restart both counters: a clear, entry into sleep, a change of the oscillator frequency select, and a clock-failure report. A hardware enable forces the watchdog on. A software enable starts or stops it only while the hardware enable is off. All pins are plain control and status lines. No data stream passes through the block, so no pin uses a valid/ready handshake.

Top module: `wdog_windowed`

## Requirements
- R1: The base counter starts at zero and advances by one on each cycle where `tick` is 1 and the watchdog runs. `win_flag` is 1 exactly when the base count is 192 (0xC0) or more, that is, when its two top bits are both 1.
- R2: With select value k, a timeout occurs on the base wrap (255 to 0) that completes 256·2^k ticks since the last restart. Select 0 times out on every wrap. The request appears on the cycle after the edge that samples the final tick.
- R3: `rst_req` and `wake_req` are single-cycle pulses that are never both 1. Issuing either one restarts both counters from zero.
- R4: Each of the following zeroes both counters at the next edge without producing a request: an accepted `clr_stb`, a `sleep_stb`, a `fsel_chg_stb`, or a `clk_fail_stb`.
- R5: The watchdog runs when `hw_en` is 1, or when `hw_en` is 0 and `sw_en` is 1. While it is stopped, both counters are held at zero and neither request is produced.
- R6: When `win_en_n` is 0, a running watchdog that sees `clr_stb` while `win_flag` is 0 pulses `rst_req` on the next cycle and restarts the counters. A `clr_stb` while `win_flag` is 1 is accepted as a clear.
- R7: When `win_en_n` is 1, `clr_stb` is accepted at any base count.
- R8: `sleep_stb` puts the block in the asleep state. A timeout while asleep produces `wake_req` instead of `rst_req`, and that wake-up returns the block to the awake state.
- R9: Changing `ps_sel` does not clear either counter. The new value governs the next wrap comparison.
- R10: After reset both requests are 0 and `win_flag` is 0. When a clear event or window fault lands on the same cycle as a wrap, it takes priority over the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle tick from the slow internal oscillator |
| hw_en | input | 1 | Hardware enable; forces the watchdog on |
| sw_en | input | 1 | Software enable, honoured while hw_en is 0 |
| clr_stb | input | 1 | Clear strobe from software |
| sleep_stb | input | 1 | Sleep-entry strobe |
| fsel_chg_stb | input | 1 | Strobe on a change of oscillator frequency select |
| clk_fail_stb | input | 1 | Strobe on a detected clock failure |
| win_en_n | input | 1 | Active-low window-mode enable |
| ps_sel | input | 4 | Postscaler tap select, divide by 2^ps_sel |
| rst_req | output | 1 | One-cycle reset request |
| wake_req | output | 1 | One-cycle wake-up request |
| win_flag | output | 1 | 1 while base count is in its last quarter |

## Verification
The timeout path is exercised with select values 0 and 2. The uninterrupted runs show that the tap divides by the right power of two. A select change mid-count shows that the change alone does not restart the period.

Clears from each of the four sources are placed well inside a period. Each is followed by exactly the tick count that reaches the next wrap, so a clear that failed to zero the counters would produce an early, unexpected request.

Clears inside and outside the window, with window mode on and off, separate an accepted clear from a fault. Sleep followed by a full period separates the wake-up path from the reset path. Running with the enables off, and with only the software enable on, separates the two enable rules.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    REQ_NONE  = 2'd0,
    REQ_RESET = 2'd1,
    REQ_WAKE  = 2'd2
  } wd_req_e;
endpackage

// File: rtl/wdog_base_cnt.sv
module wdog_base_cnt #(
  parameter int BASE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  output logic              wrap,
  output logic              win
);
  localparam logic [BASE_W-1:0] MAX_CNT = {BASE_W{1'b1}};

  logic [BASE_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (adv)  cnt_q <= cnt_q + 1'b1;
  end

  assign wrap = adv && (cnt_q == MAX_CNT);
  // last quarter: both top bits set
  assign win  = &cnt_q[BASE_W-1 -: 2];
endmodule

// File: rtl/wdog_postscaler.sv
module wdog_postscaler #(
  parameter int POST_W = 16,
  parameter int SEL_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);
  logic [POST_W-1:0] cnt_q;
  logic [POST_W-1:0] mask;

  // low 'sel' bits all ones means the next advance carries out of tap sel-1
  always_comb begin
    for (int i = 0; i < POST_W; i++) begin
      mask[i] = (i < int'(sel));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (adv)  cnt_q <= cnt_q + 1'b1;
  end

  assign hit = adv && ((cnt_q & mask) == mask);
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hw_en,
  input  logic sw_en,
  input  logic tick,
  input  logic clr_stb,
  input  logic sleep_stb,
  input  logic fsel_chg_stb,
  input  logic clk_fail_stb,
  input  logic win_en_n,
  input  logic win,
  input  logic hit,
  output logic adv,
  output logic cnt_clr,
  output logic rst_req,
  output logic wake_req
);
  logic    run, clr_ok, clr_evt, fault, tmo;
  logic    asleep_q;
  wd_req_e req_d, req_q;

  assign run     = hw_en | sw_en;
  assign clr_ok  = win_en_n | win;
  assign fault   = run & clr_stb & ~clr_ok;
  assign clr_evt = sleep_stb | fsel_chg_stb | clk_fail_stb | (clr_stb & clr_ok);
  assign tmo     = run & hit & ~clr_evt & ~fault;
  assign adv     = run & tick;
  assign cnt_clr = ~run | clr_evt | fault | tmo;

  always_comb begin
    req_d = REQ_NONE;
    if (fault)         req_d = REQ_RESET;
    else if (tmo)      req_d = asleep_q ? REQ_WAKE : REQ_RESET;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= REQ_NONE;
      asleep_q <= 1'b0;
    end else begin
      req_q <= req_d;
      if (sleep_stb)                asleep_q <= 1'b1;
      else if (req_d == REQ_WAKE)   asleep_q <= 1'b0;
    end
  end

  assign rst_req  = (req_q == REQ_RESET);
  assign wake_req = (req_q == REQ_WAKE);
endmodule

// File: rtl/wdog_windowed.sv
module wdog_windowed #(
  parameter int BASE_W = 8,
  parameter int POST_W = 16,
  parameter int SEL_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             hw_en,
  input  logic             sw_en,
  input  logic             clr_stb,
  input  logic             sleep_stb,
  input  logic             fsel_chg_stb,
  input  logic             clk_fail_stb,
  input  logic             win_en_n,
  input  logic [SEL_W-1:0] ps_sel,
  output logic             rst_req,
  output logic             wake_req,
  output logic             win_flag
);
  logic adv, cnt_clr, wrap, hit;

  wdog_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sw_en(sw_en), .tick(tick),
    .clr_stb(clr_stb), .sleep_stb(sleep_stb), .fsel_chg_stb(fsel_chg_stb),
    .clk_fail_stb(clk_fail_stb), .win_en_n(win_en_n), .win(win_flag),
    .hit(hit), .adv(adv), .cnt_clr(cnt_clr),
    .rst_req(rst_req), .wake_req(wake_req)
  );

  wdog_base_cnt #(.BASE_W(BASE_W)) u_base (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .adv(adv),
    .wrap(wrap), .win(win_flag)
  );

  wdog_postscaler #(.POST_W(POST_W), .SEL_W(SEL_W)) u_post (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .adv(wrap),
    .sel(ps_sel), .hit(hit)
  );
endmodule

// File: rtl/wdog_windowed_chk.sv
module wdog_windowed_chk #(
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             hw_en,
  input logic             sw_en,
  input logic             clr_stb,
  input logic             sleep_stb,
  input logic             fsel_chg_stb,
  input logic             clk_fail_stb,
  input logic             win_en_n,
  input logic [SEL_W-1:0] ps_sel,
  input logic             rst_req,
  input logic             wake_req,
  input logic             win_flag
);
  assert_rst_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  assert_wake_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req);

  assert_req_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && wake_req));

  assert_stopped_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_en && !sw_en) |=> (!rst_req && !wake_req && !win_flag));

  assert_clear_zeroes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_stb || fsel_chg_stb || clk_fail_stb) |=> (!win_flag && !rst_req && !wake_req));

  assert_open_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((hw_en || sw_en) && clr_stb && win_en_n) |=> (!win_flag && !rst_req));

  assert_window_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((hw_en || sw_en) && clr_stb && !win_en_n && !win_flag) |=> (rst_req && !win_flag));

  assert_window_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((hw_en || sw_en) && clr_stb && !win_en_n && win_flag) |=> (!rst_req && !win_flag));
endmodule

bind wdog_windowed wdog_windowed_chk #(.SEL_W(SEL_W)) u_chk (.*);

// File: tb/tb_wdog_windowed.sv
module tb_wdog_windowed;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, hw_en = 1'b0, sw_en = 1'b0;
  logic       clr_stb = 1'b0, sleep_stb = 1'b0, fsel_chg_stb = 1'b0, clk_fail_stb = 1'b0;
  logic       win_en_n = 1'b1;
  logic [3:0] ps_sel = 4'd0;
  logic       rst_req, wake_req, win_flag;

  localparam int K_RST  = 1;
  localparam int K_WAKE = 2;

  typedef struct { int kind; string tag; } exp_t;
  exp_t exp_q[$];

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  wdog_windowed dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hw_en(hw_en), .sw_en(sw_en),
    .clr_stb(clr_stb), .sleep_stb(sleep_stb), .fsel_chg_stb(fsel_chg_stb),
    .clk_fail_stb(clk_fail_stb), .win_en_n(win_en_n), .ps_sel(ps_sel),
    .rst_req(rst_req), .wake_req(wake_req), .win_flag(win_flag)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_req(int kind, string tag);
    exp_t e;
    e.kind = kind; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: every request pulse must match the next queued expectation
  always @(negedge clk) begin
    if (rst_n && !done && (rst_req || wake_req)) begin
      int act;
      act = (rst_req ? K_RST : 0) + (wake_req ? K_WAKE : 0);
      if (exp_q.size() == 0) check("unexpected request", act, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, act, e.kind);
      end
    end
  end

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic queue_empty(string tag);
    repeat (2) @(negedge clk);
    check(tag, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    wait (cyc > 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset rst_req", rst_req, 0);
    check("R10 reset wake_req", wake_req, 0);
    check("R10 reset win_flag", win_flag, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R2: select 0, timeout each wrap
    hw_en = 1'b1;
    ticks(191); check("R1 count 0xBF flag", win_flag, 0);
    ticks(1);   check("R1 count 0xC0 flag", win_flag, 1);
    ticks(63);  check("R2 no request at 0xFF", rst_req, 0);
    expect_req(K_RST, "R2 sel0 timeout");
    ticks(1);
    check("R3 request present", rst_req, 1);
    @(negedge clk);
    check("R3 pulse single cycle", rst_req, 0);
    check("R3 counter restarted", win_flag, 0);
    queue_empty("R2 sel0 all matched");

    // R2: select 2 -> 1024 ticks
    ps_sel = 4'd2;
    ticks(1023);
    expect_req(K_RST, "R2 sel2 timeout");
    ticks(1);
    queue_empty("R2 sel2 all matched");

    // R9: select change mid-period does not clear
    ps_sel = 4'd0;
    ticks(200);
    ps_sel = 4'd1;
    ticks(56);   // wrap with postscaler 0: no timeout under sel 1
    ticks(255);
    expect_req(K_RST, "R9 select change kept count");
    ticks(1);
    queue_empty("R9 all matched");
    ps_sel = 4'd0;

    // R7/R4: open-mode clear outside window
    ticks(100);
    clr_stb = 1'b1; @(negedge clk); clr_stb = 1'b0;
    check("R7 clear accepted no reset", rst_req, 0);
    ticks(255);
    expect_req(K_RST, "R7 period after clear");
    ticks(1);
    queue_empty("R7 all matched");

    // R4: frequency-select change and clock fail clear counters
    ticks(200);
    fsel_chg_stb = 1'b1; @(negedge clk); fsel_chg_stb = 1'b0;
    check("R4 fsel clears flag", win_flag, 0);
    ticks(200);
    clk_fail_stb = 1'b1; @(negedge clk); clk_fail_stb = 1'b0;
    check("R4 clock fail clears flag", win_flag, 0);
    ticks(255);
    expect_req(K_RST, "R4 period after clear sources");
    ticks(1);
    queue_empty("R4 all matched");

    // R6: window mode
    win_en_n = 1'b0;
    ticks(50);
    expect_req(K_RST, "R6 early clear fault");
    clr_stb = 1'b1; @(negedge clk); clr_stb = 1'b0;
    check("R6 fault raises rst_req", rst_req, 1);
    ticks(192);
    check("R6 in window", win_flag, 1);
    clr_stb = 1'b1; @(negedge clk); clr_stb = 1'b0;
    check("R6 in-window clear no reset", rst_req, 0);
    ticks(191); check("R6 restarted flag", win_flag, 0);
    ticks(64);
    expect_req(K_RST, "R6 period after window clear");
    ticks(1);
    queue_empty("R6 all matched");
    win_en_n = 1'b1;

    // R8: sleep
    ticks(100);
    sleep_stb = 1'b1; @(negedge clk); sleep_stb = 1'b0;
    check("R8 sleep clears flag", win_flag, 0);
    ticks(255);
    expect_req(K_WAKE, "R8 wake while asleep");
    ticks(1);
    ticks(255);
    expect_req(K_RST, "R8 awake again reset");
    ticks(1);
    queue_empty("R8 all matched");

    // R5: enables
    ticks(200);
    hw_en = 1'b0; sw_en = 1'b0;
    @(negedge clk);
    check("R5 stopped holds zero", win_flag, 0);
    ticks(600);
    win_en_n = 1'b0;
    clr_stb = 1'b1; @(negedge clk); clr_stb = 1'b0;
    check("R5 stopped no fault", rst_req, 0);
    win_en_n = 1'b1;
    sw_en = 1'b1;
    ticks(255);
    expect_req(K_RST, "R5 software enable runs");
    ticks(1);
    queue_empty("R5 sw run matched");
    hw_en = 1'b1;
    ticks(255);
    expect_req(K_RST, "R5 hw forces run");
    ticks(1);
    queue_empty("R5 all matched");

    // R10: clear on the wrap cycle wins over timeout
    ticks(255);
    tick = 1'b1; clr_stb = 1'b1; @(negedge clk); tick = 1'b0; clr_stb = 1'b0;
    check("R10 clear beats timeout", rst_req, 0);
    queue_empty("R10 all matched");

    finish_run();
  end
endmodule